// File: doc/BRIEF.md
# Configurable Macrocell Register

This block models one register of a programmable-logic macrocell as seen from its configuration. A static configuration word picks which of eight clock candidates drives the register, which of four terms gates its capture, and how a block-wide initialization term and two local product terms reach its preset and clear. The clock candidates are four block clocks, one product-term clock in true and inverted form, a shared product-term clock, and a constant low. The enable candidates are an initialization/enable product term in true and inverted form, the shared product-term clock, and a constant high.

All inputs are sampled on one system clock. A rising edge of the selected clock is a 0-to-1 change between two samples. Preset and clear act on the output in the same cycle they are asserted, and they outrank capture. A power-on reset input, asserted asynchronously and released through two flops, loads the configuration and drives the output to a power-up value. That value follows from the initialization wiring. The configuration is read only while reset is in force.

Top module: `mcell_reg`

## Requirements
- R1: While reset is in force, and on the first active cycle after it, the output equals 1 exactly when the block-init use bit (cfg[5]) and the swap bit (cfg[6]) are both 1; otherwise it equals 0.
- R2: Clock select cfg[2:0] picks 0..3 block clock 0..3, 4 product-term clock, 5 its inverse, 6 shared product-term clock, 7 constant low.
- R3: Enable select cfg[4:3] picks 0 the init/enable term, 1 its inverse, 2 the shared product-term clock, 3 constant high.
- R4: The register loads d_i only in a cycle where the selected clock sampled 1 after sampling 0 in the previous cycle and the selected enable is 1; otherwise it holds.
- R5: With clock select 7, the register never loads, whatever the enable.
- R6: With cfg[5]=1, block init clears the output when cfg[6]=0 and sets it when cfg[6]=1; with cfg[5]=0 it has no effect.
- R7: With the local-term bit cfg[7]=1, the local set and clear terms set and clear the output; with cfg[7]=0 they have no effect.
- R8: When a set and a clear are active in the same cycle, the output is 0.
- R9: Set and clear change the output in the cycle they are applied, without waiting for a selected-clock edge, and the stored value keeps the result after they drop.
- R10: Changes to cfg_i after reset release have no effect until the next reset.
- R11: After por_n_i rises, reset stays in force for two system clock edges; por_n_i low forces reset at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| por_n_i | input | 1 | Power-on reset, active low |
| cfg_i | input | 8 | Configuration word |
| blk_clk_i | input | 4 | Block clocks |
| pt_clk_i | input | 1 | Product-term clock |
| shr_clk_i | input | 1 | Shared product-term clock |
| pt_ice_i | input | 1 | Initialization/enable product term |
| blk_init_i | input | 1 | Block-level initialization term |
| loc_set_i | input | 1 | Local set product term |
| loc_clr_i | input | 1 | Local clear product term |
| d_i | input | 1 | Data input |
| q_o | output | 1 | Register output |

## Verification
The assertions take for granted that every input is stable around the system clock edge, so that one sample per cycle fully describes the selected clock, the enable and the control terms. They also take for granted that por_n_i is held low long enough for the internal reset to be in force before the configuration matters. The bench drives every input on the falling system edge and pulls por_n_i low across several edges before each new configuration. Selected clocks are toggled no faster than once per sample.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int MC_NBLK   = 4;
  localparam int MC_NSRC   = MC_NBLK + 4;
  localparam int MC_CSEL_W = $clog2(MC_NSRC);
  localparam int MC_ESEL_W = 2;
  localparam int MC_SYNC_N = 2;

  typedef struct packed {
    logic                 loc_en;
    logic                 swap;
    logic                 blk_en;
    logic [MC_ESEL_W-1:0] ce_sel;
    logic [MC_CSEL_W-1:0] clk_sel;
  } mc_cfg_t;

  localparam int MC_CFG_W = $bits(mc_cfg_t);

  typedef enum logic [MC_ESEL_W-1:0] {
    CE_TERM = 2'd0,
    CE_TERM_N = 2'd1,
    CE_SHARED = 2'd2,
    CE_HIGH = 2'd3
  } ce_sel_e;

  localparam logic [MC_CSEL_W-1:0] CSEL_GND = MC_CSEL_W'(MC_NSRC - 1);
endpackage

// File: rtl/mcell_rst_sync.sv
module mcell_rst_sync #(
  parameter int STAGES = mcell_pkg::MC_SYNC_N
) (
  input  logic clk_i,
  input  logic por_n_i,
  output logic run_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign run_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/mcell_cfg_hold.sv
module mcell_cfg_hold
  import mcell_pkg::*;
(
  input  logic    clk_i,
  input  logic    por_n_i,
  input  logic    run_n_i,
  input  mc_cfg_t cfg_i,
  output mc_cfg_t cfg_q_o,
  output mc_cfg_t cfg_act_o,
  output logic    pwrup_o
);
  mc_cfg_t cfg_q;
  mc_cfg_t cfg_d;
  logic    load_en;

  always_comb begin
    load_en = !run_n_i;
    cfg_d   = load_en ? cfg_i : cfg_q;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  always_comb begin
    cfg_act_o = run_n_i ? cfg_q : cfg_i;
    pwrup_o   = cfg_act_o.blk_en & cfg_act_o.swap;
  end

  assign cfg_q_o = cfg_q;
endmodule

// File: rtl/mcell_src_sel.sv
module mcell_src_sel
  import mcell_pkg::*;
#(
  parameter int NBLK = MC_NBLK
) (
  input  logic                 clk_i,
  input  logic                 por_n_i,
  input  logic [MC_CSEL_W-1:0] clk_sel_i,
  input  logic [MC_ESEL_W-1:0] ce_sel_i,
  input  logic [NBLK-1:0]      blk_clk_i,
  input  logic                 pt_clk_i,
  input  logic                 shr_clk_i,
  input  logic                 pt_ice_i,
  output logic                 cap_o
);
  localparam int NSRC = NBLK + 4;

  logic [NSRC-1:0] src_vec;
  logic            sel_clk;
  logic            sel_ce;
  logic            prev_q;
  logic            prev_d;

  genvar g;
  generate
    for (g = 0; g < NBLK; g++) begin : g_blk
      assign src_vec[g] = blk_clk_i[g];
    end
  endgenerate
  assign src_vec[NBLK]     = pt_clk_i;
  assign src_vec[NBLK + 1] = ~pt_clk_i;
  assign src_vec[NBLK + 2] = shr_clk_i;
  assign src_vec[NBLK + 3] = 1'b0;

  always_comb begin
    sel_clk = 1'b0;
    if (int'(clk_sel_i) < NSRC) sel_clk = src_vec[clk_sel_i];
  end

  always_comb begin
    unique case (ce_sel_e'(ce_sel_i))
      CE_TERM:   sel_ce = pt_ice_i;
      CE_TERM_N: sel_ce = ~pt_ice_i;
      CE_SHARED: sel_ce = shr_clk_i;
      default:   sel_ce = 1'b1;
    endcase
  end

  always_comb begin
    prev_d = sel_clk;
    cap_o  = sel_clk & ~prev_q & sel_ce;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) prev_q <= 1'b1;
    else          prev_q <= prev_d;
  end
endmodule

// File: rtl/mcell_init_route.sv
module mcell_init_route (
  input  logic blk_en_i,
  input  logic swap_i,
  input  logic loc_en_i,
  input  logic blk_init_i,
  input  logic loc_set_i,
  input  logic loc_clr_i,
  output logic set_o,
  output logic clr_o
);
  logic blk_hit;
  logic loc_set;
  logic loc_clr;

  always_comb begin
    blk_hit = blk_en_i & blk_init_i;
    loc_set = loc_en_i & loc_set_i;
    loc_clr = loc_en_i & loc_clr_i;
    set_o   = loc_set | (blk_hit & swap_i);
    clr_o   = loc_clr | (blk_hit & ~swap_i);
  end
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
(
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic [MC_CFG_W-1:0] cfg_i,
  input  logic [MC_NBLK-1:0]  blk_clk_i,
  input  logic                pt_clk_i,
  input  logic                shr_clk_i,
  input  logic                pt_ice_i,
  input  logic                blk_init_i,
  input  logic                loc_set_i,
  input  logic                loc_clr_i,
  input  logic                d_i,
  output logic                q_o
);
  logic    run_n;
  mc_cfg_t cfg_q;
  mc_cfg_t cfg_act;
  logic    pwrup;
  logic    cap_ok;
  logic    eff_set;
  logic    eff_clr;
  logic    q_reg;
  logic    q_nxt;
  logic    q_now;

  mcell_rst_sync #(.STAGES(MC_SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .run_n_o (run_n)
  );

  mcell_cfg_hold u_cfg (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .run_n_i   (run_n),
    .cfg_i     (mc_cfg_t'(cfg_i)),
    .cfg_q_o   (cfg_q),
    .cfg_act_o (cfg_act),
    .pwrup_o   (pwrup)
  );

  mcell_src_sel #(.NBLK(MC_NBLK)) u_src (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .clk_sel_i (cfg_act.clk_sel),
    .ce_sel_i  (cfg_act.ce_sel),
    .blk_clk_i (blk_clk_i),
    .pt_clk_i  (pt_clk_i),
    .shr_clk_i (shr_clk_i),
    .pt_ice_i  (pt_ice_i),
    .cap_o     (cap_ok)
  );

  mcell_init_route u_route (
    .blk_en_i   (cfg_act.blk_en),
    .swap_i     (cfg_act.swap),
    .loc_en_i   (cfg_act.loc_en),
    .blk_init_i (blk_init_i),
    .loc_set_i  (loc_set_i),
    .loc_clr_i  (loc_clr_i),
    .set_o      (eff_set),
    .clr_o      (eff_clr)
  );

  always_comb begin
    if (!run_n)       q_now = pwrup;
    else if (eff_clr) q_now = 1'b0;
    else if (eff_set) q_now = 1'b1;
    else              q_now = q_reg;
  end

  always_comb begin
    q_nxt = q_now;
    if (run_n && !eff_clr && !eff_set && cap_ok) q_nxt = d_i;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) q_reg <= 1'b0;
    else          q_reg <= q_nxt;
  end

  assign q_o = q_now;
endmodule

// File: rtl/mcell_reg_chk.sv
module mcell_reg_chk
  import mcell_pkg::*;
(
  input logic    clk_i,
  input logic    por_n_i,
  input logic    run_n,
  input mc_cfg_t cfg_q,
  input mc_cfg_t cfg_act,
  input logic    eff_set,
  input logic    eff_clr,
  input logic    cap_ok,
  input logic    q_o
);
  a_r1_pwrup: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !run_n |-> q_o == (cfg_act.blk_en & cfg_act.swap));

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!por_n_i)
    run_n && eff_clr |-> !q_o);

  a_r9_set_now: assert property (@(posedge clk_i) disable iff (!por_n_i)
    run_n && eff_set && !eff_clr |-> q_o);

  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!por_n_i)
    run_n && $past(run_n) |-> $stable(cfg_q));

  a_r5_gnd_hold: assert property (@(posedge clk_i) disable iff (!por_n_i)
    run_n && $past(run_n) && cfg_q.clk_sel == CSEL_GND && !eff_set && !eff_clr
      && !$past(eff_set) && !$past(eff_clr) |-> q_o == $past(q_o));

  a_r4_hold_no_cap: assert property (@(posedge clk_i) disable iff (!por_n_i)
    run_n && $past(run_n) && !$past(cap_ok) && !eff_set && !eff_clr
      && !$past(eff_set) && !$past(eff_clr) |-> q_o == $past(q_o));
endmodule

bind mcell_reg mcell_reg_chk u_chk (
  .clk_i   (clk_i),
  .por_n_i (por_n_i),
  .run_n   (run_n),
  .cfg_q   (cfg_q),
  .cfg_act (cfg_act),
  .eff_set (eff_set),
  .eff_clr (eff_clr),
  .cap_ok  (cap_ok),
  .q_o     (q_o)
);

// File: tb/sim_mcell_reg.sv
module sim_mcell_reg;
  logic       clk_i = 1'b0;
  logic       por_n_i;
  logic [7:0] cfg_i;
  logic [3:0] blk_clk_i;
  logic       pt_clk_i, shr_clk_i, pt_ice_i, blk_init_i;
  logic       loc_set_i, loc_clr_i, d_i;
  logic       q_o;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  // reference model state
  int   m_sync;
  bit   m_prev;
  bit   m_q;
  bit [7:0] m_cfg;
  bit   por_v;
  int   sr_pct;
  bit   cfg_wander;
  bit   force_both;

  always #2.5 clk_i = ~clk_i;

  mcell_reg u0 (
    .clk_i(clk_i), .por_n_i(por_n_i), .cfg_i(cfg_i), .blk_clk_i(blk_clk_i),
    .pt_clk_i(pt_clk_i), .shr_clk_i(shr_clk_i), .pt_ice_i(pt_ice_i),
    .blk_init_i(blk_init_i), .loc_set_i(loc_set_i), .loc_clr_i(loc_clr_i),
    .d_i(d_i), .q_o(q_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic bit sel_clk(bit [7:0] c);
    case (c[2:0])
      3'd0, 3'd1, 3'd2, 3'd3: return blk_clk_i[c[1:0]];
      3'd4: return pt_clk_i;
      3'd5: return !pt_clk_i;
      3'd6: return shr_clk_i;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit sel_ce(bit [7:0] c);
    case (c[4:3])
      2'd0: return pt_ice_i;
      2'd1: return !pt_ice_i;
      2'd2: return shr_clk_i;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] act_cfg();
    return (m_sync < 2) ? bit'(1) ? cfg_i : m_cfg : m_cfg;
  endfunction

  function automatic bit pw(bit [7:0] c);
    return c[5] & c[6];
  endfunction

  function automatic bit m_set(bit [7:0] c);
    return (c[7] & loc_set_i) | (c[5] & c[6] & blk_init_i);
  endfunction

  function automatic bit m_clr(bit [7:0] c);
    return (c[7] & loc_clr_i) | (c[5] & !c[6] & blk_init_i);
  endfunction

  function automatic bit m_out();
    bit [7:0] c;
    c = act_cfg();
    if (m_sync < 2) return pw(c);
    if (m_clr(c)) return 1'b0;
    if (m_set(c)) return 1'b1;
    return m_q;
  endfunction

  task automatic step(string tag);
    bit exp;
    bit [7:0] c;
    @(negedge clk_i);
    por_n_i    = por_v;
    blk_clk_i  = 4'($urandom);
    pt_clk_i   = 1'($urandom);
    shr_clk_i  = 1'($urandom);
    pt_ice_i   = 1'($urandom);
    d_i        = 1'($urandom);
    blk_init_i = ($urandom % 100) < sr_pct;
    loc_set_i  = ($urandom % 100) < sr_pct;
    loc_clr_i  = ($urandom % 100) < sr_pct;
    if (force_both) begin loc_set_i = 1'b1; loc_clr_i = 1'b1; end
    if (cfg_wander && m_sync >= 2) cfg_i = 8'($urandom);
    if (!por_v) begin m_sync = 0; m_prev = 1'b1; end
    #1;
    exp = m_out();
    n_run++;
    if (q_o !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected %b (cfg=%h)", tag, q_o, exp, cfg_i);
    end
    @(posedge clk_i);
    c = act_cfg();
    if (!por_v) begin
      m_q = 1'b0;
    end else begin
      if (m_sync < 2) begin
        m_q   = pw(c);
        m_cfg = cfg_i;
      end else if (m_clr(c)) m_q = 1'b0;
      else if (m_set(c)) m_q = 1'b1;
      else if (sel_clk(c) && !m_prev && sel_ce(c)) m_q = d_i;
      m_prev = sel_clk(c);
      if (m_sync < 2) m_sync++;
    end
  endtask

  task automatic restart(bit [7:0] c, string tag);
    cfg_i = c;
    por_v = 1'b0;
    for (int i = 0; i < 3; i++) step(tag);
    por_v = 1'b1;
    for (int i = 0; i < 3; i++) step(tag);
  endtask

  initial begin
    por_n_i = 1'b0; cfg_i = '0; blk_clk_i = '0; pt_clk_i = 0; shr_clk_i = 0;
    pt_ice_i = 0; blk_init_i = 0; loc_set_i = 0; loc_clr_i = 0; d_i = 0;
    m_sync = 0; m_prev = 1; m_q = 0; m_cfg = '0; por_v = 0;
    sr_pct = 0; cfg_wander = 0; force_both = 0;

    // R11: release takes two edges, output held at power-up value meanwhile
    restart(8'h60, "R11");
    for (int i = 0; i < 8; i++) step("R11");

    // R2 and R5: every clock select with enable forced high
    for (int cs = 0; cs < 8; cs++) begin
      restart({5'b00011, 3'(cs)}, cs == 7 ? "R5" : "R2");
      for (int i = 0; i < 30; i++) step(cs == 7 ? "R5" : "R2");
    end
    // R5: ground clock with every enable source
    for (int ce = 0; ce < 4; ce++) begin
      restart({3'b000, 2'(ce), 3'd7}, "R5");
      for (int i = 0; i < 20; i++) step("R5");
    end

    // R3: every enable select, block clock 0 then product-term clock
    for (int ce = 0; ce < 4; ce++) begin
      restart({3'b000, 2'(ce), 3'd0}, "R3");
      for (int i = 0; i < 30; i++) step("R3");
      restart({3'b000, 2'(ce), 3'd4}, "R4");
      for (int i = 0; i < 30; i++) step("R4");
    end

    // R1, R6, R7: all init wirings including the swap
    for (int m = 0; m < 8; m++) begin
      sr_pct = 0;
      restart({3'(m), 2'd3, 3'd6}, "R1");
      step("R1");
      sr_pct = 20;
      for (int i = 0; i < 40; i++) step(m[0] ? "R6" : "R7");
    end

    // R8: set and clear together
    sr_pct = 0;
    restart(8'h9B, "R8");
    force_both = 1;
    for (int i = 0; i < 10; i++) step("R8");
    force_both = 0;

    // R9: set/clear act at once, stored value persists
    sr_pct = 25;
    restart(8'h9F, "R9");
    for (int i = 0; i < 40; i++) step("R9");

    // R10: config changes after release are ignored
    sr_pct = 10;
    restart(8'hA4, "R10");
    cfg_wander = 1;
    for (int i = 0; i < 60; i++) step("R10");
    cfg_wander = 0;
    restart(8'h1D, "R10");
    for (int i = 0; i < 20; i++) step("R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule